// File: doc/BRIEF.md
# Periodic Sync-Word Frame Serializer

This block emits an endless serial bit stream cut into frames of fixed length. Every frame opens with a constant 16-bit sync word, sent most-significant bit first. Every bit after the sync word is zero until the frame ends, and the next frame follows with no idle bit. One bit leaves on each rising clock edge. An internal position counter reloads the sync word at each frame boundary, so the block needs no external load pulse.

A one-cycle frame-start strobe marks the first bit of each frame, so a receiver or a downstream test harness knows where frames begin. The sync word, its width and the frame length are parameters. The defaults give the word 0xAC52 in 1600-bit frames.

Top module: `sync_frame_tx`

## Requirements
- R1: While `rst` is high at a rising edge, the block enters frame position 0: in the following cycle `sdo` is 1 (bit 15 of 0xAC52) and `frame_start` is 1.
- R2: In free-running operation `frame_start` is high for exactly one clock per frame, and consecutive strobes are exactly FRAME_BITS (1600) clocks apart.
- R3: Frame positions 0 to 15 carry the sync word 0xAC52 MSB first: position p presents word bit 15-p, where position 0 is the cycle in which `frame_start` is high.
- R4: Frame positions 16 to 1599 present `sdo` = 0.
- R5: Position 1599 of one frame is followed directly by position 0 of the next frame, with no gap bit.
- R6: `frame_start` is high only in a cycle in which `sdo` shows bit 15 of the sync word.
- R7: Asserting `rst` in the middle of a frame abandons that frame. The stream restarts at position 0 with the full sync word.
- R8: The first rising edge after `rst` is released advances the stream to position 1 (`sdo` = word bit 14 = 0, `frame_start` = 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock; one serial bit per rising edge |
| rst | input | 1 | Synchronous reset, active high |
| sdo | output | 1 | Serial data output, registered |
| frame_start | output | 1 | High during the first bit of each frame, registered |

## Verification
Three frames run back to back after a clean reset. Every bit and every strobe is compared against a reference built from the frame position. This separates a wrong sync-word bit order or value (R3) from stray ones in the zero fill (R4), and separates a counter that is one cycle off (R2, R5) from a correct one. A reset pulse in the middle of a frame, issued once the counter is far into the zero fill, shows whether the reset reloads the sync word and clears the counter together (R7). The bits just after release show whether the first edge advances the stream or repeats position 0 (R8).

// File: rtl/sync_frame_tx.sv
module sync_frame_tx #(
  parameter int SYNC_BITS  = 16,
  parameter logic [SYNC_BITS-1:0] SYNC_WORD = 16'hAC52,
  parameter int FRAME_BITS = 1600
) (
  input  logic clk,
  input  logic rst,
  output logic sdo,
  output logic frame_start
);
  localparam int PW = (FRAME_BITS > 1) ? $clog2(FRAME_BITS) : 1;
  localparam logic [PW-1:0] LAST = PW'(FRAME_BITS - 1);

  logic [SYNC_BITS-1:0] shreg;
  logic [PW-1:0]        pos;
  logic                 fs_q;
  logic                 wrap;

  assign wrap = (pos == LAST);

  always_ff @(posedge clk) begin
    if (rst || wrap) begin
      shreg <= SYNC_WORD;
      pos   <= '0;
    end else begin
      shreg <= {shreg[SYNC_BITS-2:0], 1'b0};
      pos   <= pos + 1'b1;
    end
    fs_q <= rst || wrap;
  end

  assign sdo         = shreg[SYNC_BITS-1];
  assign frame_start = fs_q;

  // R1: reset lands on position 0 with the strobe up
  p_reset_entry_r1: assert property (@(posedge clk) rst |=> (frame_start && sdo == SYNC_WORD[SYNC_BITS-1]));
  // R2: strobe lasts one cycle in free run
  p_strobe_single_r2: assert property (@(posedge clk) disable iff (rst) frame_start |=> !frame_start);
  // R6: strobe aligned with the sync-word MSB
  p_strobe_msb_r6: assert property (@(posedge clk) disable iff (rst) frame_start |-> sdo == SYNC_WORD[SYNC_BITS-1]);
  // R4: zero fill after the sync word
  p_fill_zero_r4: assert property (@(posedge clk) disable iff (rst) (pos >= PW'(SYNC_BITS) && !frame_start) |-> !sdo);
  // R5: last position wraps straight into a new frame
  p_wrap_r5: assert property (@(posedge clk) disable iff (rst) wrap |=> (frame_start && pos == '0));
  // R2: counter stays inside the frame
  p_pos_bound_r2: assert property (@(posedge clk) disable iff (rst) pos <= LAST);

  initial begin
    a_len_ok_r2: assert (FRAME_BITS >= SYNC_BITS && SYNC_BITS >= 2);
  end
endmodule

// File: tb/sync_frame_tx_bench.sv
module sync_frame_tx_bench;
  localparam int SB = 16;
  localparam logic [15:0] WORD = 16'hAC52;
  localparam int FB = 1600;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sdo, frame_start;
  int total = 0;
  int bad = 0;
  longint cyc = 0;

  sync_frame_tx #(.SYNC_BITS(SB), .SYNC_WORD(WORD), .FRAME_BITS(FB)) u_sync_frame_tx (
    .clk(clk), .rst(rst), .sdo(sdo), .frame_start(frame_start)
  );

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic ref_bit(int p);
    return (p < SB) ? WORD[SB-1-p] : 1'b0;
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cyc);
    end
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk(sdo == 1'b1, "R1 sdo", sdo, 1);
    chk(frame_start == 1'b1, "R1 frame_start", frame_start, 1);
  endtask

  // Starts at the negedge showing position 0 (reset still high), releases reset.
  task automatic t_frames(input int nframes);
    longint last_fs = -1;
    int strobes = 0;
    rst = 1'b0;
    for (int k = 0; k < nframes * FB; k++) begin
      int p = k % FB;
      logic eb = ref_bit(p);
      if (p < SB) chk(sdo == eb, "R3 sync bit", sdo, eb);
      else if (sdo !== 1'b0) chk(1'b0, "R4 zero fill", sdo, 0);
      if (p == FB - 1 || (p == 0 && k > 0))
        chk(sdo == eb, "R5 boundary bit", sdo, eb);
      if (frame_start !== (p == 0))
        chk(1'b0, "R2 strobe position", frame_start, p == 0);
      if (frame_start) begin
        chk(sdo == WORD[SB-1], "R6 strobe with MSB", sdo, WORD[SB-1]);
        if (last_fs >= 0) chk(cyc - last_fs == FB, "R2 strobe period", cyc - last_fs, FB);
        last_fs = cyc;
        strobes++;
      end
      @(negedge clk);
    end
    chk(strobes == nframes, "R2 strobe count", strobes, nframes);
  endtask

  task automatic t_midframe_reset();
    repeat (700) @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    chk(sdo == 1'b1 && frame_start == 1'b1, "R7 restart at position 0", {sdo, frame_start}, 3);
    rst = 1'b0;
    @(negedge clk);
    chk(sdo == WORD[SB-2], "R8 first bit after release", sdo, WORD[SB-2]);
    chk(frame_start == 1'b0, "R8 strobe low after release", frame_start, 0);
    for (int p = 2; p < 40; p++) begin
      @(negedge clk);
      chk(sdo == ref_bit(p), "R7 sync word after reset", sdo, ref_bit(p));
      if (frame_start) chk(1'b0, "R7 no extra strobe", 1, 0);
    end
  endtask

  bit finished = 1'b0;

  initial begin
    t_reset();
    t_frames(3);
    t_midframe_reset();
    t_reset();
    t_frames(1);
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #800000;
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule